// File: doc/BRIEF.md
# Serial Port Interrupt Identification Unit

This block is the interrupt arbiter of a 16550-style serial port. It takes the four interrupt enable bits and five raw interrupt conditions: a receive line error, receive data at the trigger level, a receive character timeout, a transmit-FIFO-empty level, and a modem-status change. It reduces them to one priority-coded identification byte and an interrupt request line.

Three of the sources are sticky: the line-error source, the modem-change source and the transmit-holding-empty source. Each is captured on the rising edge of its raw input and held until the matching side-effect strobe clears it. The host decoder pulses that strobe for one cycle when the status register is read, when the identification register is read, or when the transmit holding register is written. The two receive sources are levels owned by the receive FIFO and pass straight through. The identification value is combinational from the captured state and the current inputs, so the bus can read it in the same cycle.

Top module: `uirq_ident_unit`

## Requirements
- R1: After reset, with all inputs low, `iir_val` is 0x01 and `irq` is 0.
- R2: A source whose enable bit is 0 is never reported. Enable bit 0 gates receive data, bit 1 gates transmit-holding-empty, bit 2 gates the line error, and bit 3 gates the modem change.
- R3: `iir_val[3:1]` carries the code of the reported source: line error 011, receive data 010, timeout 110, transmit-holding-empty 001, modem change 000. It is 000 when nothing is pending.
- R4: When several enabled sources are pending, only the highest is reported. The order from highest to lowest is line error, receive data, timeout, transmit-holding-empty, modem change.
- R5: The timeout source is gated by enable bit 0, the same bit as receive data.
- R6: `iir_val[0]` is 0 while a source is pending and 1 otherwise, and `irq` is always its inverse.
- R7: The transmit-holding-empty source is set one clock after `tx_empty` rises from 0 to 1. A `tx_empty` that stays high does not set it again.
- R8: Pulsing `iir_rd` while transmit-holding-empty is the reported source clears that source at the next edge. Pulsing `iir_rd` while another source is reported leaves it set.
- R9: Pulsing `thr_wr` clears transmit-holding-empty at the next edge. This clear wins over a simultaneous rising edge of `tx_empty`.
- R10: The line-error and modem-change sources are set one clock after their raw input rises. They are held until `lsr_rd` or `msr_rd` respectively clears them. A new rise in the same cycle as the clear wins.
- R11: `iir_val[5:4]` is 00, and `iir_val[7:6]` is 11 when `fifo_mode` is 1 and 00 when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier_en | input | 4 | Interrupt enable bits |
| ls_err | input | 1 | Raw receive line error condition |
| rx_at_trig | input | 1 | Receive FIFO at trigger level |
| rx_timeout | input | 1 | Receive character timeout |
| tx_empty | input | 1 | Transmit FIFO empty level |
| ms_change | input | 1 | Raw modem-status change |
| iir_rd | input | 1 | One-cycle strobe: identification register read |
| thr_wr | input | 1 | One-cycle strobe: transmit holding register write |
| lsr_rd | input | 1 | One-cycle strobe: line status register read |
| msr_rd | input | 1 | One-cycle strobe: modem status register read |
| fifo_mode | input | 1 | FIFOs enabled, selects the upper identification bits |
| iir_val | output | 8 | Identification register value |
| irq | output | 1 | Interrupt request, active high |

## Verification
Setting a sticky source and clearing it can land on the same clock edge. For the line-error source the new rise must survive. For transmit-holding-empty the holding-register write must win. The bench raises `ls_err` in the same cycle as `lsr_rd`, and `tx_empty` in the same cycle as `thr_wr`, then reads the identification byte one edge later and again after the raw input stays level. A second overlap is an identification read while a higher source hides transmit-holding-empty: the read must leave that source intact, and it reappears once the higher source drops.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

   // number of interrupt sources, ranked 0 (highest) .. NSRC-1 (lowest)
   localparam int NSRC   = 5;
   localparam int ID_W   = 3;
   localparam int EN_W   = 4;

   typedef enum logic [ID_W-1:0] {
      ID_MODEM   = 3'b000,
      ID_TXHOLD  = 3'b001,
      ID_RXDATA  = 3'b010,
      ID_LINE    = 3'b011,
      ID_TIMEOUT = 3'b110
   } irq_id_e;

   // rank to identification code
   function automatic logic [ID_W-1:0] id_of_rank(input int rank);
      case (rank)
         0:       id_of_rank = ID_LINE;
         1:       id_of_rank = ID_RXDATA;
         2:       id_of_rank = ID_TIMEOUT;
         3:       id_of_rank = ID_TXHOLD;
         default: id_of_rank = ID_MODEM;
      endcase
   endfunction

endpackage

// File: rtl/uirq_event_latch.sv
// Sticky source flag: set by its raw input, cleared by a read strobe.
// A set in the same cycle as a clear wins.
module uirq_event_latch #(
   parameter bit SET_ON_EDGE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   input  logic clr_i,
   output logic flag_o
);

   logic set_w;
   logic flag_q;

   generate
      if (SET_ON_EDGE) begin : g_edge
         logic raw_prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) raw_prev_q <= 1'b0;
            else        raw_prev_q <= raw_i;
         end
         assign set_w = raw_i & ~raw_prev_q;
      end else begin : g_level
         assign set_w = raw_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_q <= 1'b0;
      else if (set_w) flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

   AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !raw_i) |=> !flag_q); // R10

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && set_w) |=> flag_q); // R10

endmodule

// File: rtl/uirq_txhold_track.sv
// Transmit-holding-empty source: set on the rising edge of tx_empty,
// cleared by a holding-register write (wins) or by an identification
// read while this source is the one reported.
module uirq_txhold_track (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_empty_i,
   input  logic thr_wr_i,
   input  logic iir_rd_i,
   input  logic reported_i,
   output logic flag_o
);

   logic empty_prev_q;
   logic rise_w;
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) empty_prev_q <= 1'b0;
      else        empty_prev_q <= tx_empty_i;
   end

   assign rise_w = tx_empty_i & ~empty_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        flag_q <= 1'b0;
      else if (thr_wr_i)                 flag_q <= 1'b0;
      else if (rise_w)                   flag_q <= 1'b1;
      else if (iir_rd_i && reported_i)   flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

   AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      thr_wr_i |=> !flag_q); // R9

   AST_SET_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(tx_empty_i)); // R7

   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (iir_rd_i && reported_i && !tx_empty_i) |=> !flag_q); // R8

   AST_READ_OTHER_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (iir_rd_i && !reported_i && !thr_wr_i && flag_q) |=> flag_q); // R8

endmodule

// File: rtl/uirq_prio_enc.sv
// Fixed-priority encoder: request 0 is highest. Emits a one-hot grant,
// the code of the granted rank and an any-request flag.
module uirq_prio_enc
   import uirq_pkg::*;
#(
   parameter int N = NSRC
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N-1:0]    req_i,
   output logic [N-1:0]    grant_o,
   output logic [ID_W-1:0] code_o,
   output logic            any_o
);

   logic [N:0] blocked_w;

   generate
      if (N < 1) begin : g_bad_n
         $error("uirq_prio_enc: N must be at least 1");
      end
   endgenerate

   assign blocked_w[0] = 1'b0;

   generate
      for (genvar i = 0; i < N; i++) begin : g_rank
         assign grant_o[i]     = req_i[i] & ~blocked_w[i];
         assign blocked_w[i+1] = blocked_w[i] | req_i[i];
      end
   endgenerate

   assign any_o = blocked_w[N];

   always_comb begin
      code_o = '0;
      for (int i = 0; i < N; i++) begin
         if (grant_o[i]) code_o = code_o | id_of_rank(i);
      end
   end

   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o)); // R4

   AST_TOP_RANK: assert property (@(posedge clk) disable iff (!rst_n)
      req_i[0] |-> grant_o[0]); // R4

endmodule

// File: rtl/uirq_ident_unit.sv
module uirq_ident_unit
   import uirq_pkg::*;
#(
   parameter int ENABLE_W   = EN_W,
   parameter bit EDGE_STICKY = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ENABLE_W-1:0] ier_en,
   input  logic                ls_err,
   input  logic                rx_at_trig,
   input  logic                rx_timeout,
   input  logic                tx_empty,
   input  logic                ms_change,
   input  logic                iir_rd,
   input  logic                thr_wr,
   input  logic                lsr_rd,
   input  logic                msr_rd,
   input  logic                fifo_mode,
   output logic [7:0]          iir_val,
   output logic                irq
);

   // enable bit positions
   localparam int EB_RX   = 0;
   localparam int EB_TX   = 1;
   localparam int EB_LINE = 2;
   localparam int EB_MDM  = 3;

   // source ranks
   localparam int RK_LINE = 0;
   localparam int RK_RX   = 1;
   localparam int RK_TO   = 2;
   localparam int RK_TX   = 3;
   localparam int RK_MDM  = 4;

   generate
      if (ENABLE_W != 4) begin : g_bad_en
         $error("uirq_ident_unit: ENABLE_W must be 4");
      end
   endgenerate

   logic            line_flag;
   logic            mdm_flag;
   logic            tx_flag;
   logic [NSRC-1:0] req_w;
   logic [NSRC-1:0] grant_w;
   logic [ID_W-1:0] code_w;
   logic            any_w;

   uirq_event_latch #(.SET_ON_EDGE(EDGE_STICKY)) u_line (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (ls_err),
      .clr_i  (lsr_rd),
      .flag_o (line_flag)
   );

   uirq_event_latch #(.SET_ON_EDGE(EDGE_STICKY)) u_modem (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (ms_change),
      .clr_i  (msr_rd),
      .flag_o (mdm_flag)
   );

   uirq_txhold_track u_txhold (
      .clk        (clk),
      .rst_n      (rst_n),
      .tx_empty_i (tx_empty),
      .thr_wr_i   (thr_wr),
      .iir_rd_i   (iir_rd),
      .reported_i (grant_w[RK_TX]),
      .flag_o     (tx_flag)
   );

   always_comb begin
      req_w          = '0;
      req_w[RK_LINE] = line_flag  & ier_en[EB_LINE];
      req_w[RK_RX]   = rx_at_trig & ier_en[EB_RX];
      req_w[RK_TO]   = rx_timeout & ier_en[EB_RX];
      req_w[RK_TX]   = tx_flag    & ier_en[EB_TX];
      req_w[RK_MDM]  = mdm_flag   & ier_en[EB_MDM];
   end

   uirq_prio_enc #(.N(NSRC)) u_enc (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_i   (req_w),
      .grant_o (grant_w),
      .code_o  (code_w),
      .any_o   (any_w)
   );

   assign iir_val = {{2{fifo_mode}}, 2'b00, code_w, ~any_w};
   assign irq     = any_w;

   AST_LINE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (line_flag && ier_en[EB_LINE]) |-> (iir_val[3:1] == 3'b011)); // R4

   AST_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (ier_en == '0) |-> (iir_val[0] && !irq)); // R2

   AST_TIMEOUT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (!ier_en[EB_RX]) |-> (iir_val[3:1] != 3'b110)); // R5

   AST_UPPER_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      (iir_val[5:4] == 2'b00) && (iir_val[7:6] == {2{fifo_mode}})); // R11

endmodule

// File: tb/tb_uirq_ident_unit.sv
module tb_uirq_ident_unit;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] ier_en = '0;
   logic       ls_err = 0, rx_at_trig = 0, rx_timeout = 0, tx_empty = 0, ms_change = 0;
   logic       iir_rd = 0, thr_wr = 0, lsr_rd = 0, msr_rd = 0, fifo_mode = 0;
   logic [7:0] iir_val;
   logic       irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   typedef struct {
      logic [7:0] exp;
      string      tag;
   } item_t;
   item_t sb_q[$];

   always #5 clk = ~clk;

   uirq_ident_unit dut (
      .clk(clk), .rst_n(rst_n), .ier_en(ier_en), .ls_err(ls_err),
      .rx_at_trig(rx_at_trig), .rx_timeout(rx_timeout), .tx_empty(tx_empty),
      .ms_change(ms_change), .iir_rd(iir_rd), .thr_wr(thr_wr), .lsr_rd(lsr_rd),
      .msr_rd(msr_rd), .fifo_mode(fifo_mode), .iir_val(iir_val), .irq(irq)
   );

   // driver: inputs already set at a falling edge; expectation is the
   // value after the next rising edge
   task automatic cyc(input logic [7:0] exp, input string tag);
      @(posedge clk);
      sb_q.push_back('{exp: exp, tag: tag});
      @(negedge clk);
   endtask

   // monitor
   always @(posedge clk) begin
      #2;
      if (sb_q.size() > 0) begin
         item_t it;
         it = sb_q.pop_front();
         checks++;
         if (iir_val !== it.exp || irq !== ~it.exp[0]) begin
            errors++;
            $display("FAIL %s: iir_val=%h irq=%b expected iir_val=%h irq=%b",
                     it.tag, iir_val, irq, it.exp, ~it.exp[0]);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cyc(8'h01, "R1 reset state");
      fifo_mode = 1; cyc(8'hC1, "R11 fifo mode upper bits");
      fifo_mode = 0;
      // receive data
      rx_at_trig = 1; cyc(8'h01, "R2 rx masked");
      ier_en = 4'b0001; cyc(8'h04, "R3 rx code / R6 irq");
      rx_at_trig = 0; rx_timeout = 1; cyc(8'h0C, "R3 timeout code");
      ier_en = 4'b1110; cyc(8'h01, "R5 timeout gated by bit0");
      rx_timeout = 0;
      // transmit holding empty
      ier_en = 4'b0010; tx_empty = 1; cyc(8'h02, "R7 set on rise");
      cyc(8'h02, "R7 held");
      iir_rd = 1; cyc(8'h01, "R8 read clears reported");
      iir_rd = 0; cyc(8'h01, "R7 level does not reassert");
      tx_empty = 0; cyc(8'h01, "R7 low");
      tx_empty = 1; cyc(8'h02, "R7 new rise");
      ier_en = 4'b0011; rx_at_trig = 1; cyc(8'h04, "R4 rx above tx");
      iir_rd = 1; cyc(8'h04, "R8 read while other reported");
      iir_rd = 0; rx_at_trig = 0; cyc(8'h02, "R8 tx kept");
      thr_wr = 1; cyc(8'h01, "R9 write clears");
      thr_wr = 0; tx_empty = 0; cyc(8'h01, "R9 low");
      tx_empty = 1; thr_wr = 1; cyc(8'h01, "R9 write beats rise");
      thr_wr = 0; cyc(8'h01, "R9 no late set");
      tx_empty = 0;
      // line error
      ier_en = 4'b0100; ls_err = 1; cyc(8'h06, "R10 line set");
      ls_err = 0; cyc(8'h06, "R10 line sticky");
      lsr_rd = 1; cyc(8'h01, "R10 line cleared");
      lsr_rd = 0; cyc(8'h01, "R10 stays clear");
      ls_err = 1; lsr_rd = 1; cyc(8'h06, "R10 set beats clear");
      ls_err = 0; lsr_rd = 0; cyc(8'h06, "R10 still set");
      lsr_rd = 1; cyc(8'h01, "R10 cleared again");
      lsr_rd = 0;
      // modem change
      ier_en = 4'b1000; ms_change = 1; cyc(8'h00, "R10 modem set / R3 code");
      ms_change = 0; cyc(8'h00, "R10 modem sticky");
      msr_rd = 1; cyc(8'h01, "R10 modem cleared");
      msr_rd = 0;
      // full priority ladder
      ier_en = 4'b1111; ls_err = 1; rx_at_trig = 1; rx_timeout = 1;
      tx_empty = 1; ms_change = 1; cyc(8'h06, "R4 line highest");
      ls_err = 0; lsr_rd = 1; cyc(8'h04, "R4 rx next");
      lsr_rd = 0; rx_at_trig = 0; cyc(8'h0C, "R4 timeout next");
      rx_timeout = 0; cyc(8'h02, "R4 tx next");
      thr_wr = 1; cyc(8'h00, "R4 modem last");
      thr_wr = 0; ms_change = 0; msr_rd = 1; cyc(8'h01, "R4 all clear");
      msr_rd = 0;
      fifo_mode = 1; ls_err = 1; ier_en = 4'b0100; cyc(8'hC6, "R11 upper bits with pending");
      @(posedge clk); #3;
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule